// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block decides, in the same cycle that an access is presented, whether an instruction fetch, a load or a store is allowed. It holds a parameterised set of protection entries, up to 16. Each entry has an address register, which holds a word address (byte address bits 31:2), and a configuration byte. The configuration byte gives read, write and execute permission and one of four address-matching modes: off, top-of-range, a single aligned four-byte word, or an aligned power-of-two region.

Only user-mode accesses are filtered. A machine-mode access is never restricted, because there is no lock bit. Loads and stores are judged by the actual current privilege, because no modified-privilege override exists. A denied user access drives `accAllow` low, and the surrounding pipeline turns that into an access-fault exception. Software programs the entries through two simple write ports, one for configuration bytes and one for address registers. Each write port selects its entry by index.

Top module: `mpc_top`

## Requirements
- R1: After reset every entry is off and every address register is zero. A user-mode access is then denied and a machine-mode access is allowed.
- R2: When `privUser` is 0 (machine mode), `accAllow` is 1 whatever the entries hold and whatever the access kind.
- R3: A user-mode access that matches no entry whose mode is not off is denied.
- R4: When several entries match, the lowest-numbered matching entry alone decides the permission, even when a later entry would grant it.
- R5: The access kind encoding is 0 = fetch, 1 = load, 2 = store and 3 = reserved. A fetch needs the execute bit (config bit 2), a load needs the read bit (bit 0) and a store needs the write bit (bit 1). A reserved kind in user mode is always denied.
- R6: Config bits [4:3] select the mode: 0 off, 1 top-of-range, 2 naturally aligned four-byte, 3 naturally aligned power-of-two. An entry whose mode is off never matches, whatever its permission bits. Config bits [7:5] have no effect.
- R7: In top-of-range mode, entry i matches when the word address of the access is at least the address register of entry i-1 and below its own address register. Entry 0 uses zero as its lower bound. The lower bound is taken regardless of the mode of entry i-1.
- R8: In naturally aligned four-byte mode, an entry matches exactly the four bytes whose word address equals its address register.
- R9: In power-of-two mode, t trailing ones in the address register select an aligned region of 2^(t+3) bytes. The region's base is the register with those ones cleared, shifted left by two. An all-ones register matches every address.
- R10: A write with `cfgWrEn` or `addrWrEn` high updates the indexed entry at the next rising clock edge. The decision changes only after that edge. A write whose index is NUM_ENTRIES or higher changes no entry.
- R11: `accAllow` is a combinational function of the access inputs and the entry state. A change of `accAddr`, `accKind` or `privUser` is reflected without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for a configuration byte |
| cfgWrIdx | input | 4 | Entry index for the configuration write |
| cfgWrData | input | 8 | Configuration byte: bit0 R, bit1 W, bit2 X, bits[4:3] mode |
| addrWrEn | input | 1 | Write strobe for an address register |
| addrWrIdx | input | 4 | Entry index for the address write |
| addrWrData | input | ADDR_W-2 | Word address value (byte address bits 31:2) |
| accAddr | input | ADDR_W | Byte address of the access being checked |
| accKind | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved |
| privUser | input | 1 | 1 when the access is made in user mode |
| accAllow | output | 1 | 1 when the access is permitted |

## Verification
Each matching mode is probed at its edges. Four-byte mode is probed at the first and last byte of its word and at the next word. Power-of-two mode is probed at the region base, its last byte and the bytes just outside it. Top-of-range mode is probed at both bounds, including the zero bound of entry 0, which shows whether the boundary comparisons are inclusive or exclusive. Overlapping entries whose permission bits conflict show whether priority follows the entry number. The same address is tried under each access kind, which shows whether each kind is tied to its own permission bit. Machine-mode and reserved-kind accesses, writes with an out-of-range index, and a write timed against a steady access show how privilege, ignored writes and the one-cycle write latency affect the decision.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int MAX_ENTRIES = 16;
  localparam int IDX_W       = 4;
  localparam int CFG_W       = 8;

  localparam int BIT_R    = 0;
  localparam int BIT_W    = 1;
  localparam int BIT_X    = 2;
  localparam int MODE_LSB = 3;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } matchMode_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_e;

  typedef struct packed {
    logic [MAX_ENTRIES-1:0] cfgLoad;
    logic [MAX_ENTRIES-1:0] addrLoad;
    logic [2:0]             needPerm;
  } ctrlStrobe_t;
endpackage

// File: rtl/mpc_ctrl.sv
module mpc_ctrl
  import mpc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgWrIdx,
  input  logic             addrWrEn,
  input  logic [IDX_W-1:0] addrWrIdx,
  input  logic [1:0]       accKind,
  output ctrlStrobe_t      strobe
);

  for (genvar i = 0; i < MAX_ENTRIES; i++) begin : gDec
    if (i < NUM_ENTRIES) begin : gLive
      assign strobe.cfgLoad[i]  = cfgWrEn  && (cfgWrIdx  == IDX_W'(i));
      assign strobe.addrLoad[i] = addrWrEn && (addrWrIdx == IDX_W'(i));
    end else begin : gDead
      assign strobe.cfgLoad[i]  = 1'b0;
      assign strobe.addrLoad[i] = 1'b0;
    end
  end

  always_comb begin
    strobe.needPerm = 3'b000;
    unique case (accKind_e'(accKind))
      ACC_FETCH: strobe.needPerm[BIT_X] = 1'b1;
      ACC_LOAD:  strobe.needPerm[BIT_R] = 1'b1;
      ACC_STORE: strobe.needPerm[BIT_W] = 1'b1;
      default:   strobe.needPerm = 3'b000;
    endcase
  end

  AST_CFG_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.cfgLoad)); // R10
  AST_ADDR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.addrLoad)); // R10
  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (int'(cfgWrIdx) >= NUM_ENTRIES)) |-> (strobe.cfgLoad == '0)); // R10
  AST_ONE_NEED: assert property (@(posedge clk) disable iff (!rstN)
    (accKind != 2'd3) |-> ($countones(strobe.needPerm) == 1)); // R5

endmodule

// File: rtl/mpc_dpath.sv
module mpc_dpath
  import mpc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 32,
  localparam int WORD_W     = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [WORD_W-1:0] addrWrData,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              privUser,
  output logic              accAllow
);

  logic [WORD_W-1:0] wordAddr;
  logic [WORD_W-1:0] addrArr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [NUM_ENTRIES-1:0] permVec;
  logic selOk;
  logic unusedBits;

  assign wordAddr   = accAddr[ADDR_W-1:2];
  assign unusedBits = ^{accAddr[1:0], strobe};

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEnt
    logic [CFG_W-1:0]  cfgQ;
    logic [WORD_W-1:0] addrQ;
    logic [WORD_W-1:0] lowBound;
    logic [WORD_W-1:0] napotMask;
    logic              unusedCfg;
    matchMode_e        mode;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ  <= '0;
        addrQ <= '0;
      end else begin
        if (strobe.cfgLoad[i])  cfgQ  <= cfgWrData;
        if (strobe.addrLoad[i]) addrQ <= addrWrData;
      end
    end

    assign addrArr[i] = addrQ;
    assign mode       = matchMode_e'(cfgQ[MODE_LSB+1:MODE_LSB]);
    assign unusedCfg  = ^cfgQ[CFG_W-1:MODE_LSB+2];
    assign napotMask  = addrQ ^ (addrQ + 1'b1);

    if (i == 0) begin : gBase
      assign lowBound = '0;
    end else begin : gPrev
      assign lowBound = addrArr[i-1];
    end

    always_comb begin
      unique case (mode)
        MODE_TOR:   hitVec[i] = (wordAddr >= lowBound) && (wordAddr < addrQ);
        MODE_NA4:   hitVec[i] = (wordAddr == addrQ);
        MODE_NAPOT: hitVec[i] = ((wordAddr ^ addrQ) & ~napotMask) == '0;
        default:    hitVec[i] = 1'b0;
      endcase
    end

    assign permVec[i] = ((cfgQ[2:0] & strobe.needPerm) == strobe.needPerm);

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      strobe.cfgLoad[i] |=> (cfgQ == $past(cfgWrData))); // R10
    AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      strobe.addrLoad[i] |=> (addrQ == $past(addrWrData))); // R10
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
      (mode == MODE_OFF) |-> !hitVec[i]); // R6
  end

  always_comb begin
    selOk = 1'b0;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
      if (hitVec[k]) selOk = permVec[k];
    end
  end

  assign accAllow = !privUser || (selOk && (strobe.needPerm != 3'b000));

  AST_MACHINE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    !privUser |-> accAllow); // R2
  AST_NOMATCH_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (privUser && (hitVec == '0)) |-> !accAllow); // R3
  AST_FIRST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (privUser && hitVec[0] && !permVec[0]) |-> !accAllow); // R4

endmodule

// File: rtl/mpc_top.sv
module mpc_top
  import mpc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [3:0]        cfgWrIdx,
  input  logic [7:0]        cfgWrData,
  input  logic              addrWrEn,
  input  logic [3:0]        addrWrIdx,
  input  logic [ADDR_W-3:0] addrWrData,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accKind,
  input  logic              privUser,
  output logic              accAllow
);

  ctrlStrobe_t strobe;

  mpc_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgWrIdx (cfgWrIdx),
    .addrWrEn (addrWrEn),
    .addrWrIdx(addrWrIdx),
    .accKind  (accKind),
    .strobe   (strobe)
  );

  mpc_dpath #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgWrData (cfgWrData),
    .addrWrData(addrWrData),
    .accAddr   (accAddr),
    .privUser  (privUser),
    .accAllow  (accAllow)
  );

endmodule

// File: tb/sim_mpc_top.sv
module sim_mpc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgWrIdx = '0;
  logic [7:0]  cfgWrData = '0;
  logic        addrWrEn = 1'b0;
  logic [3:0]  addrWrIdx = '0;
  logic [29:0] addrWrData = '0;
  logic [31:0] accAddr = '0;
  logic [1:0]  accKind = '0;
  logic        privUser = 1'b0;
  logic        accAllow;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mpc_top u0 (.*);

  task automatic check(input logic exp, input string tag);
    nChecks++;
    if (accAllow !== exp) begin
      nFails++;
      $display("FAIL %s: accAllow=%b expected %b (addr=%h kind=%0d user=%b)",
               tag, accAllow, exp, accAddr, accKind, privUser);
    end
  endtask

  task automatic probe(input logic usr, input logic [1:0] kind,
                       input logic [31:0] a, input logic exp, input string tag);
    @(negedge clk);
    privUser = usr; accKind = kind; accAddr = a;
    #1 check(exp, tag);
  endtask

  task automatic setCfg(input logic [3:0] idx, input logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrIdx = idx; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setAddr(input logic [3:0] idx, input logic [29:0] v);
    @(negedge clk);
    addrWrEn = 1'b1; addrWrIdx = idx; addrWrData = v;
    @(negedge clk);
    addrWrEn = 1'b0;
  endtask

  task automatic testReset();
    probe(1'b1, 2'd1, 32'h0000_0100, 1'b0, "R1 user denied after reset");
    probe(1'b0, 2'd1, 32'h0000_0100, 1'b1, "R1 machine allowed after reset");
  endtask

  task automatic testNa4();
    setAddr(4'd0, 30'h400);
    setCfg(4'd0, 8'h11);
    probe(1'b1, 2'd1, 32'h0000_1000, 1'b1, "R8 first byte");
    probe(1'b1, 2'd1, 32'h0000_1003, 1'b1, "R8 last byte");
    probe(1'b1, 2'd1, 32'h0000_1004, 1'b0, "R3 next word unmatched");
    probe(1'b1, 2'd2, 32'h0000_1000, 1'b0, "R5 store without W");
    probe(1'b1, 2'd0, 32'h0000_1000, 1'b0, "R5 fetch without X");
    setCfg(4'd0, 8'hF1);
    probe(1'b1, 2'd1, 32'h0000_1000, 1'b1, "R6 upper cfg bits ignored");
  endtask

  task automatic testNapot();
    setAddr(4'd1, 30'h807);
    setCfg(4'd1, 8'h1F);
    probe(1'b1, 2'd1, 32'h0000_2000, 1'b1, "R9 region base");
    probe(1'b1, 2'd2, 32'h0000_203F, 1'b1, "R9 region last byte");
    probe(1'b1, 2'd1, 32'h0000_2040, 1'b0, "R9 above region");
    probe(1'b1, 2'd1, 32'h0000_1FFC, 1'b0, "R9 below region");
    probe(1'b1, 2'd0, 32'h0000_2010, 1'b1, "R5 fetch with X");
  endtask

  task automatic testTor();
    setAddr(4'd2, 30'hC00);
    setCfg(4'd2, 8'h09);
    probe(1'b1, 2'd1, 32'h0000_2FFC, 1'b1, "R7 just below top");
    probe(1'b1, 2'd1, 32'h0000_3000, 1'b0, "R7 top exclusive");
    probe(1'b1, 2'd1, 32'h0000_2040, 1'b1, "R7 inside range");
    probe(1'b1, 2'd2, 32'h0000_2FFC, 1'b0, "R5 store on read-only range");
    probe(1'b1, 2'd2, 32'h0000_2010, 1'b1, "R4 earlier NAPOT entry wins");
    setAddr(4'd0, 30'h040);
    setCfg(4'd0, 8'h09);
    probe(1'b1, 2'd1, 32'h0000_0000, 1'b1, "R7 entry0 zero lower bound");
    probe(1'b1, 2'd1, 32'h0000_00FC, 1'b1, "R7 entry0 below top");
    probe(1'b1, 2'd1, 32'h0000_0100, 1'b0, "R7 entry0 top exclusive");
    probe(1'b1, 2'd1, 32'h0000_1000, 1'b0, "R3 old NA4 word now unmatched");
  endtask

  task automatic testPriority();
    setAddr(4'd3, 30'h3FFF_FFFF);
    setCfg(4'd3, 8'h1F);
    probe(1'b1, 2'd2, 32'h0000_2FFC, 1'b0, "R4 read-only entry beats later RWX");
    probe(1'b1, 2'd2, 32'h0000_5000, 1'b1, "R9 all-ones matches anywhere");
    probe(1'b1, 2'd0, 32'hFFFF_FFFC, 1'b1, "R9 all-ones top address");
    probe(1'b1, 2'd3, 32'h0000_5000, 1'b0, "R5 reserved kind denied");
    probe(1'b0, 2'd3, 32'h0000_5000, 1'b1, "R2 machine reserved kind");
    probe(1'b0, 2'd2, 32'h0000_2FFC, 1'b1, "R2 machine store on read-only");
  endtask

  task automatic testOffAndWrites();
    setCfg(4'd3, 8'h07);
    probe(1'b1, 2'd1, 32'h0000_5000, 1'b0, "R6 off entry never matches");
    setCfg(4'd5, 8'h1F);
    probe(1'b1, 2'd1, 32'h0000_5000, 1'b0, "R10 out-of-range cfg write ignored");
    setAddr(4'd15, 30'h3FFF_FFFF);
    probe(1'b1, 2'd1, 32'h0000_5000, 1'b0, "R10 out-of-range addr write ignored");
    @(negedge clk);
    privUser = 1'b1; accKind = 2'd1; accAddr = 32'h0000_5000;
    cfgWrEn = 1'b1; cfgWrIdx = 4'd3; cfgWrData = 8'h1F;
    #1 check(1'b0, "R10 no effect before edge");
    @(posedge clk);
    #1 check(1'b1, "R10 effect after edge");
    @(negedge clk);
    cfgWrEn = 1'b0;
    accAddr = 32'h0000_2FFC; accKind = 2'd2;
    #1 check(1'b0, "R11 combinational address change");
    privUser = 1'b0;
    #1 check(1'b1, "R11 combinational privilege change");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testNa4();
    testNapot();
    testTor();
    testPriority();
    testOffAndWrites();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule